// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits next to a small 8-bit processor core and decides when the core must divert to a service routine, and where that routine starts. Thirteen peripheral event lines each set a sticky pending bit. Every source has its own enable bit and its own priority bit. A global enable gates all sources together. The controller presents one request and one vector address to the core, and the core takes the request only at an instruction boundary.

The controller records which priority levels are currently in service. Any pending, enabled source can interrupt idle code. A high-priority source can interrupt a low-priority routine. A return strobe from the core closes the innermost active level.

The global enable is seen by the arbiter as it stood at the previous instruction boundary. Software that clears it must therefore let one more instruction retire before masking is guaranteed. In practice this means a following instruction of two or more bytes. A simple word-wide register port gives software access to the pending, enable, global-enable and priority state.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_req` is 0 and `svc_level` is 0.
- R2: An event pulse on `src_evt[n]` sets pending bit n (register 0, bit n), whatever the state of that source's enable and of the global enable.
- R3: A write to register 0 clears each pending bit written as 0 and leaves each bit written as 1 unchanged.
- R4: A request is raised only for a source whose pending bit and enable bit (register 1, bit n) are both 1, and only while the delayed global enable is 1. The delayed global enable is the value of register 2 bit 7, captured on each cycle with `instr_done` high. A clear of the global enable written before a boundary therefore still allows a take at that boundary and masks from the next one on.
- R5: A pending bit whose source is disabled stays set and raises no request.
- R6: `irq_vec` equals 0x0003 + 8*n for the winning source n.
- R7: Sources whose priority bit (register 3, bit n) is 1 beat sources whose bit is 0. Within one level, the lowest-numbered source wins.
- R8: A take is a cycle in which `instr_done` and `irq_req` are both 1. On a take, the pending bit of the winner is cleared, and the winner's level is marked in service: `svc_level` bit 1 for high, bit 0 for low.
- R9: A high request preempts a low routine. No request is raised while a high routine is in service. A low request is not raised while a low routine is in service.
- R10: A pulse on `reti` clears `svc_level` bit 1 if it is set, and otherwise clears bit 0. `svc_level` changes only on a take or a `reti`.
- R11: An event arriving in the same cycle as a software clear, or as a hardware clear on take, leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_evt | input | 13 | Event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 enable, 2 control, 3 priority |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| instr_done | input | 1 | Instruction boundary strobe from the core |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the winning source |
| svc_level | output | 2 | In-service flags: bit 1 high, bit 0 low |

## Verification
Several properties are checked on every cycle:
- a request always points at a source that is pending and enabled under a set delayed global enable;
- the vector always lies on the 8-byte grid inside the vector range;
- an event always leaves its pending bit set;
- a take always clears the winner unless that source fires again in the same cycle;
- the in-service flags never move without a take or a return.

The bench scenarios cover the other behaviours:
- which source wins for every pair of sources under every priority mix;
- the one-boundary lag of the global enable;
- the full nesting order of preemption and return.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int          NSRC     = 13,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            instr_done,
  input  logic            reti,
  output logic            irq_req,
  output logic [15:0]     irq_vec,
  output logic [1:0]      svc_level
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] pend_q, en_q, prio_q, pend_nxt;
  logic            ge_q, ge_seen, svc_hi, svc_lo;
  logic [NSRC-1:0] cand_hi, cand_lo;
  logic            hi_hit, lo_hit, grant_hi, grant_lo, take;
  logic [IW-1:0]   hi_idx, lo_idx, win_idx;

  assign cand_hi = pend_q & en_q & prio_q & {NSRC{ge_seen}};
  assign cand_lo = pend_q & en_q & ~prio_q & {NSRC{ge_seen}};

  always_comb begin
    hi_hit = 1'b0; lo_hit = 1'b0;
    hi_idx = '0;   lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) begin hi_hit = 1'b1; hi_idx = IW'(i); end
      if (cand_lo[i]) begin lo_hit = 1'b1; lo_idx = IW'(i); end
    end
  end

  assign grant_hi  = hi_hit & ~svc_hi;
  assign grant_lo  = lo_hit & ~hi_hit & ~svc_hi & ~svc_lo;
  assign irq_req   = grant_hi | grant_lo;
  assign win_idx   = grant_hi ? hi_idx : lo_idx;
  assign irq_vec   = VEC_BASE + 16'(VEC_STEP * int'(win_idx));
  assign take      = instr_done & irq_req;
  assign svc_level = {svc_hi, svc_lo};

  always_comb begin
    pend_nxt = pend_q;
    if (reg_wr && reg_addr == 2'd0) pend_nxt = pend_nxt & reg_wdata[NSRC-1:0];
    if (take) pend_nxt[win_idx] = 1'b0;
    pend_nxt = pend_nxt | src_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; en_q <= '0; prio_q <= '0;
      ge_q <= 1'b0; ge_seen <= 1'b0;
      svc_hi <= 1'b0; svc_lo <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (reg_wr && reg_addr == 2'd1) en_q   <= reg_wdata[NSRC-1:0];
      if (reg_wr && reg_addr == 2'd2) ge_q   <= reg_wdata[7];
      if (reg_wr && reg_addr == 2'd3) prio_q <= reg_wdata[NSRC-1:0];
      if (instr_done) ge_seen <= ge_q;
      if (reti) begin
        if (svc_hi) svc_hi <= 1'b0;
        else        svc_lo <= 1'b0;
      end
      if (take) begin
        if (grant_hi) svc_hi <= 1'b1;
        else          svc_lo <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 16'(pend_q);
      2'd1:    reg_rdata = 16'(en_q);
      2'd2:    reg_rdata = {8'h00, ge_q, 7'h00};
      default: reg_rdata = 16'(prio_q);
    endcase
  end

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  // R4
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q[win_idx] && en_q[win_idx] && ge_seen));

  // R6
  vec_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((irq_vec - VEC_BASE) % 16'(VEC_STEP)) == 16'd0 &&
                 (irq_vec - VEC_BASE) < 16'(NSRC * VEC_STEP)));

  // R8
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !src_evt[win_idx]) |=> !pend_q[$past(win_idx)]);

  // R10
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !reti) |=> $stable(svc_level));
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int N = 13;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic reg_wr = 1'b0, instr_done = 1'b0, reti = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata, irq_vec;
  logic irq_req;
  logic [1:0] svc_level;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .instr_done(instr_done), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
    .svc_level(svc_level));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk); reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic evt(logic [N-1:0] m);
    @(negedge clk); src_evt = m;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic boundary();
    @(negedge clk); instr_done = 1'b1;
    @(negedge clk); instr_done = 1'b0;
  endtask

  task automatic rti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    logic [N-1:0] acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 0); end
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 svc", int'(svc_level), 0);

    // R2 / R5: disabled sources latch and stay quiet
    wr(2, 16'h0080); boundary();
    acc = '0;
    for (int n = 0; n < N; n++) begin
      evt(N'(1) << n); acc |= N'(1) << n;
      rd(0, v); chk("R2 pend", v, int'(acc));
      chk("R5 no req", int'(irq_req), 0);
    end
    // R3 selective clear
    wr(0, 16'h0AAA); rd(0, v); chk("R3 keep ones", v, 'h0AAA & int'(acc));
    wr(0, 16'h0000); rd(0, v); chk("R3 clear", v, 0);

    // R6 / R8 / R10 per-source sweep
    wr(1, 16'h1FFF);
    for (int n = 0; n < N; n++) begin
      wr(3, (n % 2) ? 16'h1FFF : 16'h0000);
      evt(N'(1) << n);
      chk("R4 req", int'(irq_req), 1);
      chk("R6 vec", int'(irq_vec), 3 + 8 * n);
      boundary();
      chk("R8 svc", int'(svc_level), (n % 2) ? 2 : 1);
      rd(0, v); chk("R8 pend cleared", v, 0);
      chk("R8 req drop", int'(irq_req), 0);
      rti();
      chk("R10 svc pop", int'(svc_level), 0);
    end

    // R7 all pairs, all priority mixes
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        for (int p = 0; p < 4; p++) begin
          int w;
          wr(3, 16'((p & 1) << i | ((p >> 1) & 1) << j));
          evt((N'(1) << i) | (N'(1) << j));
          w = ((p & 1) == ((p >> 1) & 1)) ? i : ((p & 1) ? i : j);
          chk("R7 winner", int'(irq_vec), 3 + 8 * w);
          wr(0, 16'h0000);
        end

    // R9 nesting
    wr(3, 16'h0060);
    evt(N'(1) << 8); boundary();
    chk("R9 lo svc", int'(svc_level), 1);
    evt(N'(1) << 9);
    chk("R9 lo blocks lo", int'(irq_req), 0);
    evt(N'(1) << 5);
    chk("R9 hi preempts", int'(irq_req), 1);
    chk("R9 hi vec", int'(irq_vec), 43);
    boundary();
    chk("R9 both svc", int'(svc_level), 3);
    evt(N'(1) << 6);
    chk("R9 hi blocks hi", int'(irq_req), 0);
    rti();
    chk("R10 pop hi", int'(svc_level), 1);
    chk("R9 hi after pop", int'(irq_vec), 51);
    boundary(); rti();
    chk("R9 lo still blocked", int'(irq_req), 0);
    rti();
    chk("R10 pop lo", int'(svc_level), 0);
    chk("R9 lo resumes", int'(irq_vec), 75);
    wr(0, 16'h0000);

    // R11 event beats software clear
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000; src_evt = N'(1) << 3;
    @(negedge clk); reg_wr = 1'b0; src_evt = '0;
    rd(0, v); chk("R11 sw clear", v, 1 << 3);
    wr(0, 16'h0000);
    // R11 event beats take clear
    wr(3, 16'h0000);
    evt(N'(1) << 4);
    @(negedge clk); instr_done = 1'b1; src_evt = N'(1) << 4;
    @(negedge clk); instr_done = 1'b0; src_evt = '0;
    rd(0, v); chk("R11 take clear", v, 1 << 4);
    chk("R8 svc lo", int'(svc_level), 1);
    rti(); wr(0, 16'h0000);

    // R4 delayed global enable
    wr(2, 16'h0000);
    evt(N'(1) << 2);
    chk("R4 late view", int'(irq_req), 1);
    boundary();
    chk("R4 taken at next boundary", int'(svc_level), 1);
    rti();
    evt(N'(1) << 2);
    chk("R4 masked", int'(irq_req), 0);
    rd(0, v); chk("R5 stays pending", v, 1 << 2);
    wr(2, 16'h0080);
    chk("R4 not yet seen", int'(irq_req), 0);
    boundary();
    chk("R4 now seen", int'(irq_req), 1);
    chk("R6 vec src2", int'(irq_vec), 19);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule